// File: doc/BRIEF.md
# Synchronous Flash Command Translator

This block sits between a simple bus requester and a synchronous flash device. It turns each bus read or write into a short, fixed series of flash pin cycles. Two high address bits choose the command class. A command write carries two one-byte codes in its data word: a setup code in the upper byte and a confirm code in the lower byte. The block sends them as two code cycles to the addressed bank and row, with one idle cycle between them. A plain write becomes a program-setup code cycle followed by an array data cycle. A command read fetches either the device configuration or the status register. The read value is returned to the requester after a fixed read latency.

Command traffic is legal only while the controller's write buffers are disabled. A transfer that arrives while the buffers are enabled is refused with an error response, and no cycle reaches the memory. Transfers with no defined meaning are refused in the same way. The requester holds its request until the one-cycle response pulse. The block accepts a new request only from its idle state.

Top module: `flash_cmd_xlate`

## Requirements
- R1: After reset, and in every idle cycle, mem_cmd is NOP (0), mem_dq_oe is 0, mem_bank, mem_addr and mem_dq_out are 0, and resp_ready, resp_err and resp_rdata are 0.
- R2: A write with address bit 27 set, and a setup byte (req_wdata[15:8]) of 0x20, 0x60, 0x30 or 0xA0, produces three cycles in order. The first is a CODE cycle (mem_cmd=1) with the setup byte on mem_dq_out[7:0]. The second is one NOP cycle. The third is a CODE cycle carrying the confirm byte (req_wdata[7:0]). Both CODE cycles use bank = addr[22:21] and mem_addr = row = addr[20:9]. resp_ready pulses in the cycle after the confirm cycle.
- R3: A write with bit 27 set and setup byte 0x50 produces a single CODE cycle with mem_dq_out = 0x0050, mem_bank = 0 and mem_addr = 0, whatever the address holds. The response follows in the next cycle.
- R4: A write with bit 27 clear, whatever bit 26 holds, produces two cycles and then the response. The first is a CODE cycle with 0x0040, the bank and the row. The second is a WDATA cycle (mem_cmd=2) with the full write word, the bank, and mem_addr = column = addr[8:1].
- R5: A read with bits 27 and 26 both set produces an RSTAT cycle (mem_cmd=3) with the bank and the row. mem_dq_in is sampled in the third cycle after that cycle. The response in the next cycle returns the sampled value on resp_rdata.
- R6: A read with bit 27 clear and bit 26 set produces an RCFG cycle (mem_cmd=4) with the bank and the row, then an RCOL cycle (mem_cmd=5) with the bank and the column. It then samples and responds as in R5, counting from the RCOL cycle.
- R7: If bufs_disabled is low at the edge that accepts a request, the next cycle gives resp_ready=1 with resp_err=1, and no non-NOP cycle is issued.
- R8: A read with bit 26 clear, or a write with bit 27 set and an unlisted setup byte, is answered like R7 with an error and no memory cycle.
- R9: mem_dq_oe is high exactly on CODE and WDATA cycles. resp_ready lasts one cycle and never coincides with a memory cycle. resp_rdata is 0 on write and error responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until resp_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; bits 27/26 select command class |
| req_wdata | input | 16 | Write word; setup byte high, confirm byte low |
| bufs_disabled | input | 1 | High while write buffers are off |
| mem_cmd | output | 3 | Flash cycle type: 0 NOP, 1 CODE, 2 WDATA, 3 RSTAT, 4 RCFG, 5 RCOL |
| mem_bank | output | 2 | Bank select |
| mem_addr | output | 12 | Row or column address |
| mem_dq_out | output | 16 | Data driven to flash |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | 16 | Data from flash |
| resp_ready | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Refused transfer, valid with resp_ready |
| resp_rdata | output | 16 | Read result, valid with resp_ready |

## Verification
Two checks can fall on the same clock edge: the buffer-state check and the decode of the command class. The bench provokes this by offering otherwise valid command writes, programs and reads while bufs_disabled is low. It requires that the error pulse appears one cycle later, with no pin activity at all. The response pulse of one transfer also meets the requester's still-held request. Back-to-back transfers check that the held request is not accepted a second time. Outside the single sample cycle the bench drives changing junk on mem_dq_in, so a read that samples one cycle early or late returns the wrong value.

// File: rtl/fct_pkg.sv
package fct_pkg;

  typedef enum logic [2:0] {
    MC_NOP   = 3'd0,
    MC_CODE  = 3'd1,
    MC_WDATA = 3'd2,
    MC_RSTAT = 3'd3,
    MC_RCFG  = 3'd4,
    MC_RCOL  = 3'd5
  } mcmd_e;

  typedef enum logic [2:0] {
    K_ERR, K_PAIR, K_CLR, K_PROG, K_RSTAT, K_RCFG
  } kind_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_C_SETUP, SQ_C_GAP, SQ_C_CONF, SQ_CLR,
    SQ_P_SETUP, SQ_P_DATA, SQ_R_ROW, SQ_R_COL, SQ_R_WAIT, SQ_RESP
  } seq_e;

  localparam logic [7:0] CODE_CLR  = 8'h50;
  localparam logic [7:0] CODE_PROG = 8'h40;

  // Setup bytes that open a two-phase command.
  function automatic logic pair_setup_ok(input logic [7:0] code);
    return (code == 8'h20) || (code == 8'h60) || (code == 8'h30) || (code == 8'hA0);
  endfunction

  function automatic kind_e classify(input logic wr, input logic cmd1, input logic cmd0,
                                     input logic bufs_off, input logic [7:0] setup);
    if (!bufs_off) return K_ERR;
    if (wr) begin
      if (!cmd1) return K_PROG;
      if (setup == CODE_CLR) return K_CLR;
      if (pair_setup_ok(setup)) return K_PAIR;
      return K_ERR;
    end
    if (!cmd0) return K_ERR;
    return cmd1 ? K_RSTAT : K_RCFG;
  endfunction

endpackage

// File: rtl/fct_req_decode.sv
module fct_req_decode
  import fct_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 16,
  parameter int CMD1_BIT = 27,
  parameter int CMD0_BIT = 26,
  parameter int BANK_LSB = 21,
  parameter int BANK_W   = 2,
  parameter int ROW_LSB  = 9,
  parameter int ROW_W    = 12,
  parameter int COL_LSB  = 1,
  parameter int COL_W    = 8
) (
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              bufs_off,
  output kind_e             kind,
  output logic [7:0]        setup,
  output logic [7:0]        confirm,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  assign setup   = wdata[15:8];
  assign confirm = wdata[7:0];
  assign bank    = addr[BANK_LSB +: BANK_W];
  assign row     = addr[ROW_LSB +: ROW_W];
  assign col     = addr[COL_LSB +: COL_W];
  assign kind    = classify(write, addr[CMD1_BIT], addr[CMD0_BIT], bufs_off, setup);

  logic unused_bits;
  assign unused_bits = ^{addr, wdata};
endmodule

// File: rtl/fct_seq.sv
module fct_seq
  import fct_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int RD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  kind_e             d_kind,
  input  logic [7:0]        d_setup,
  input  logic [7:0]        d_confirm,
  input  logic [BANK_W-1:0] d_bank,
  input  logic [ROW_W-1:0]  d_row,
  input  logic [COL_W-1:0]  d_col,
  input  logic [DATA_W-1:0] d_data,
  input  logic [DATA_W-1:0] mem_dq_in,
  output seq_e              state,
  output kind_e             l_kind,
  output logic [7:0]        l_setup,
  output logic [7:0]        l_confirm,
  output logic [BANK_W-1:0] l_bank,
  output logic [ROW_W-1:0]  l_row,
  output logic [COL_W-1:0]  l_col,
  output logic [DATA_W-1:0] l_data,
  output logic              resp_ready,
  output logic              resp_err,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              ev_accept,
  output logic              ev_confirm,
  output logic              ev_clr
);
  localparam int CNT_W = (RD_LAT < 2) ? 1 : $clog2(RD_LAT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RD_LAT - 1);

  seq_e              nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic              err_q;
  logic [DATA_W-1:0] rdata_q;

  assign ev_accept  = (state == SQ_IDLE) && req_valid;
  assign ev_confirm = (state == SQ_C_CONF);
  assign ev_clr     = (state == SQ_CLR);

  always_comb begin
    nxt = state;
    unique case (state)
      SQ_IDLE: if (req_valid) begin
        unique case (d_kind)
          K_PAIR:  nxt = SQ_C_SETUP;
          K_CLR:   nxt = SQ_CLR;
          K_PROG:  nxt = SQ_P_SETUP;
          K_RSTAT: nxt = SQ_R_ROW;
          K_RCFG:  nxt = SQ_R_ROW;
          default: nxt = SQ_RESP;
        endcase
      end
      SQ_C_SETUP: nxt = SQ_C_GAP;
      SQ_C_GAP:   nxt = SQ_C_CONF;
      SQ_C_CONF:  nxt = SQ_RESP;
      SQ_CLR:     nxt = SQ_RESP;
      SQ_P_SETUP: nxt = SQ_P_DATA;
      SQ_P_DATA:  nxt = SQ_RESP;
      SQ_R_ROW:   nxt = (l_kind == K_RCFG) ? SQ_R_COL : SQ_R_WAIT;
      SQ_R_COL:   nxt = SQ_R_WAIT;
      SQ_R_WAIT:  nxt = (cnt_q == CNT_LAST) ? SQ_RESP : SQ_R_WAIT;
      SQ_RESP:    nxt = SQ_IDLE;
      default:    nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      l_kind    <= K_ERR;
      l_setup   <= '0;
      l_confirm <= '0;
      l_bank    <= '0;
      l_row     <= '0;
      l_col     <= '0;
      l_data    <= '0;
      cnt_q     <= '0;
      err_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      state <= nxt;
      if (ev_accept) begin
        l_kind    <= d_kind;
        l_setup   <= d_setup;
        l_confirm <= d_confirm;
        l_bank    <= d_bank;
        l_row     <= d_row;
        l_col     <= d_col;
        l_data    <= d_data;
        err_q     <= (d_kind == K_ERR);
        rdata_q   <= '0;
      end
      if (state == SQ_R_WAIT) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) rdata_q <= mem_dq_in;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign resp_ready = (state == SQ_RESP);
  assign resp_err   = resp_ready && err_q;
  assign resp_rdata = resp_ready ? rdata_q : '0;

  // R7/R8: a refused request answers in the very next cycle, flagged as error.
  p_err_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && d_kind == K_ERR) |=> (resp_ready && resp_err));

  // R9: the response is a single-cycle pulse.
  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ready |=> !resp_ready);

  // R9: no new acceptance while a transfer is in flight.
  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !ev_accept);
endmodule

// File: rtl/fct_pins.sv
module fct_pins
  import fct_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8
) (
  input  seq_e              state,
  input  kind_e             l_kind,
  input  logic [7:0]        l_setup,
  input  logic [7:0]        l_confirm,
  input  logic [BANK_W-1:0] l_bank,
  input  logic [ROW_W-1:0]  l_row,
  input  logic [COL_W-1:0]  l_col,
  input  logic [DATA_W-1:0] l_data,
  output mcmd_e             cmd,
  output logic [BANK_W-1:0] bank,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] maddr,
  output logic [DATA_W-1:0] dq,
  output logic              oe
);
  localparam int MADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  function automatic logic [DATA_W-1:0] code_word(input logic [7:0] c);
    return DATA_W'(c);
  endfunction

  always_comb begin
    cmd   = MC_NOP;
    bank  = '0;
    maddr = '0;
    dq    = '0;
    oe    = 1'b0;
    unique case (state)
      SQ_C_SETUP, SQ_C_CONF, SQ_P_SETUP: begin
        cmd   = MC_CODE;
        bank  = l_bank;
        maddr = MADDR_W'(l_row);
        oe    = 1'b1;
        if (state == SQ_C_SETUP)      dq = code_word(l_setup);
        else if (state == SQ_C_CONF)  dq = code_word(l_confirm);
        else                          dq = code_word(CODE_PROG);
      end
      SQ_CLR: begin
        cmd = MC_CODE;
        dq  = code_word(CODE_CLR);
        oe  = 1'b1;
      end
      SQ_P_DATA: begin
        cmd   = MC_WDATA;
        bank  = l_bank;
        maddr = MADDR_W'(l_col);
        dq    = l_data;
        oe    = 1'b1;
      end
      SQ_R_ROW: begin
        cmd   = (l_kind == K_RCFG) ? MC_RCFG : MC_RSTAT;
        bank  = l_bank;
        maddr = MADDR_W'(l_row);
      end
      SQ_R_COL: begin
        cmd   = MC_RCOL;
        bank  = l_bank;
        maddr = MADDR_W'(l_col);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_cmd_xlate.sv
module flash_cmd_xlate
  import fct_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 16,
  parameter int CMD1_BIT = 27,
  parameter int CMD0_BIT = 26,
  parameter int BANK_LSB = 21,
  parameter int BANK_W   = 2,
  parameter int ROW_LSB  = 9,
  parameter int ROW_W    = 12,
  parameter int COL_LSB  = 1,
  parameter int COL_W    = 8,
  parameter int RD_LAT   = 3,
  localparam int MADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               bufs_disabled,
  output logic [2:0]         mem_cmd,
  output logic [BANK_W-1:0]  mem_bank,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_dq_out,
  output logic               mem_dq_oe,
  input  logic [DATA_W-1:0]  mem_dq_in,
  output logic               resp_ready,
  output logic               resp_err,
  output logic [DATA_W-1:0]  resp_rdata
);
  kind_e             d_kind, l_kind;
  logic [7:0]        d_setup, d_confirm, l_setup, l_confirm;
  logic [BANK_W-1:0] d_bank, l_bank;
  logic [ROW_W-1:0]  d_row, l_row;
  logic [COL_W-1:0]  d_col, l_col;
  logic [DATA_W-1:0] l_data;
  seq_e              state;
  mcmd_e             cmd_e;
  logic              ev_accept, ev_confirm, ev_clr;

  fct_req_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD1_BIT(CMD1_BIT), .CMD0_BIT(CMD0_BIT),
    .BANK_LSB(BANK_LSB), .BANK_W(BANK_W), .ROW_LSB(ROW_LSB), .ROW_W(ROW_W),
    .COL_LSB(COL_LSB), .COL_W(COL_W)
  ) u_dec (
    .write(req_write), .addr(req_addr), .wdata(req_wdata), .bufs_off(bufs_disabled),
    .kind(d_kind), .setup(d_setup), .confirm(d_confirm),
    .bank(d_bank), .row(d_row), .col(d_col)
  );

  fct_seq #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .RD_LAT(RD_LAT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .d_kind(d_kind), .d_setup(d_setup), .d_confirm(d_confirm),
    .d_bank(d_bank), .d_row(d_row), .d_col(d_col), .d_data(req_wdata),
    .mem_dq_in(mem_dq_in), .state(state),
    .l_kind(l_kind), .l_setup(l_setup), .l_confirm(l_confirm),
    .l_bank(l_bank), .l_row(l_row), .l_col(l_col), .l_data(l_data),
    .resp_ready(resp_ready), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .ev_accept(ev_accept), .ev_confirm(ev_confirm), .ev_clr(ev_clr)
  );

  fct_pins #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_pins (
    .state(state), .l_kind(l_kind), .l_setup(l_setup), .l_confirm(l_confirm),
    .l_bank(l_bank), .l_row(l_row), .l_col(l_col), .l_data(l_data),
    .cmd(cmd_e), .bank(mem_bank), .maddr(mem_addr), .dq(mem_dq_out), .oe(mem_dq_oe)
  );

  assign mem_cmd = cmd_e;

  // R2: the confirm code cycle follows one NOP, which follows the setup code cycle.
  p_confirm_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_confirm |-> ($past(mem_cmd) == 3'd0 && $past(mem_cmd, 2) == 3'd1));

  // R3: clear-status drives its fixed code with bank and address at zero.
  p_clr_zero_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr |-> (mem_bank == '0 && mem_addr == '0 && mem_dq_out == DATA_W'(8'h50)));

  // R7: an error response is preceded by a quiet memory cycle.
  p_quiet_error_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> ($past(mem_cmd) == 3'd0 && mem_cmd == 3'd0));

  // R9: the response never overlaps an issued memory cycle.
  p_resp_no_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ready |-> (mem_cmd == 3'd0 && !mem_dq_oe));
endmodule

// File: tb/flash_cmd_xlate_test.sv
module flash_cmd_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        bufs_disabled = 1'b1;
  logic [2:0]  mem_cmd;
  logic [1:0]  mem_bank;
  logic [11:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in = '0;
  logic        resp_ready, resp_err;
  logic [15:0] resp_rdata;

  flash_cmd_xlate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .bufs_disabled(bufs_disabled),
    .mem_cmd(mem_cmd), .mem_bank(mem_bank), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .resp_ready(resp_ready), .resp_err(resp_err), .resp_rdata(resp_rdata)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic        idle;
    logic [2:0]  cmd;
    logic [1:0]  bank;
    logic [11:0] addr;
    logic [15:0] dq;
    logic        oe;
    logic        rdy;
    logic        err;
    logic [15:0] rdata;
    logic        cap;
    logic [3:0]  tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   errors = 0;
  int   checks = 0;
  int   cyc = 0;
  logic [15:0] rd_val = '0;

  function automatic exp_t mk(logic [2:0] c, logic [1:0] b, logic [11:0] a,
                              logic [15:0] d, logic o, logic r, logic e,
                              logic [15:0] rd, logic cp, logic [3:0] t);
    exp_t x;
    x.idle = 1'b0; x.cmd = c; x.bank = b; x.addr = a; x.dq = d; x.oe = o;
    x.rdy = r; x.err = e; x.rdata = rd; x.cap = cp; x.tag = t;
    return x;
  endfunction

  function automatic exp_t idle_e();
    exp_t x = mk(3'd0, 2'd0, 12'd0, 16'd0, 1'b0, 1'b0, 1'b0, 16'd0, 1'b0, 4'd1);
    x.idle = 1'b1;
    return x;
  endfunction

  // Behavioural reference: expected pin activity per cycle after acceptance.
  task automatic plan_seq(input logic w, input logic [31:0] a, input logic [15:0] wd,
                          input logic bd);
    logic [1:0]  b   = a[22:21];
    logic [11:0] row = a[20:9];
    logic [11:0] col = {4'd0, a[8:1]};
    logic [7:0]  s   = wd[15:8];
    logic [7:0]  c   = wd[7:0];
    bit known = (s == 8'h20 || s == 8'h60 || s == 8'h30 || s == 8'hA0 || s == 8'h50);
    if (!bd) begin
      q.push_back(mk(0, 0, 0, 0, 0, 1, 1, 0, 0, 4'd7));               // R7
    end else if ((w && a[27] && !known) || (!w && !a[26])) begin
      q.push_back(mk(0, 0, 0, 0, 0, 1, 1, 0, 0, 4'd8));               // R8
    end else if (w && a[27] && s == 8'h50) begin
      q.push_back(mk(1, 0, 0, 16'h0050, 1, 0, 0, 0, 0, 4'd3));        // R3
      q.push_back(mk(0, 0, 0, 0, 0, 1, 0, 0, 0, 4'd3));
    end else if (w && a[27]) begin
      q.push_back(mk(1, b, row, {8'h00, s}, 1, 0, 0, 0, 0, 4'd2));    // R2
      q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 4'd2));
      q.push_back(mk(1, b, row, {8'h00, c}, 1, 0, 0, 0, 0, 4'd2));
      q.push_back(mk(0, 0, 0, 0, 0, 1, 0, 0, 0, 4'd2));
    end else if (w) begin
      q.push_back(mk(1, b, row, 16'h0040, 1, 0, 0, 0, 0, 4'd4));      // R4
      q.push_back(mk(2, b, col, wd, 1, 0, 0, 0, 0, 4'd4));
      q.push_back(mk(0, 0, 0, 0, 0, 1, 0, 0, 0, 4'd4));
    end else begin
      if (a[27]) q.push_back(mk(3, b, row, 0, 0, 0, 0, 0, 0, 4'd5));  // R5
      else begin
        q.push_back(mk(4, b, row, 0, 0, 0, 0, 0, 0, 4'd6));           // R6
        q.push_back(mk(5, b, col, 0, 0, 0, 0, 0, 0, 4'd6));
      end
      q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 4'd5));
      q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 4'd5));
      q.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd5));
      q.push_back(mk(0, 0, 0, 0, 0, 1, 0, rd_val, 0, a[27] ? 4'd5 : 4'd6));
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      q.delete();
      cur = idle_e();
    end else begin
      if (cur.idle && req_valid) plan_seq(req_write, req_addr, req_wdata, bufs_disabled);
      cur = (q.size() > 0) ? q.pop_front() : idle_e();
    end
  end

  // Flash model: the read value is present only in the sample cycle.
  always @(negedge clk) begin
    mem_dq_in <= cur.cap ? rd_val : (16'hE5E5 ^ 16'(cyc));
  end

  // Per-cycle comparison (idle cycles carry R1; R9 covered by oe/ready fields).
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (mem_cmd !== cur.cmd || mem_bank !== cur.bank || mem_addr !== cur.addr ||
          mem_dq_out !== cur.dq || mem_dq_oe !== cur.oe || resp_ready !== cur.rdy ||
          resp_err !== cur.err || resp_rdata !== cur.rdata) begin
        errors++;
        $display("FAIL R%0d cyc=%0d actual cmd=%0d bank=%0d addr=%h dq=%h oe=%b rdy=%b err=%b rd=%h expected cmd=%0d bank=%0d addr=%h dq=%h oe=%b rdy=%b err=%b rd=%h",
                 cur.tag, cyc, mem_cmd, mem_bank, mem_addr, mem_dq_out, mem_dq_oe,
                 resp_ready, resp_err, resp_rdata, cur.cmd, cur.bank, cur.addr,
                 cur.dq, cur.oe, cur.rdy, cur.err, cur.rdata);
      end
    end
  end

  function automatic logic [31:0] adr(logic c1, logic c0, logic [1:0] b,
                                      logic [11:0] r, logic [7:0] c);
    return {4'd0, c1, c0, 3'd0, b, r, c, 1'b0};
  endfunction

  task automatic xfer(input logic w, input logic [31:0] a, input logic [15:0] wd,
                      input logic bd, input logic [15:0] rv);
    @(negedge clk);
    rd_val = rv;
    req_write = w; req_addr = a; req_wdata = wd; bufs_disabled = bd; req_valid = 1'b1;
    do @(negedge clk); while (!resp_ready);
    req_valid = 1'b0;
    req_addr = 32'hFFFF_FFFF; req_wdata = 16'hFFFF;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1: reset state
    if (mem_cmd !== 3'd0 || mem_dq_oe !== 1'b0 || resp_ready !== 1'b0 || resp_err !== 1'b0) begin
      errors++;
      $display("FAIL R1 actual cmd=%0d oe=%b rdy=%b err=%b expected 0 0 0 0",
               mem_cmd, mem_dq_oe, resp_ready, resp_err);
    end
    // R2: two-phase command pairs
    xfer(1, adr(1, 0, 2'd2, 12'hABC, 8'h11), 16'h20D0, 1, 0);
    xfer(1, adr(1, 1, 2'd1, 12'h123, 8'h00), 16'h6001, 1, 0);
    xfer(1, adr(1, 0, 2'd3, 12'hFFF, 8'hFF), 16'h60F1, 1, 0);
    xfer(1, adr(1, 0, 2'd0, 12'h001, 8'h80), 16'h60D0, 1, 0);
    xfer(1, adr(1, 0, 2'd1, 12'h800, 8'h01), 16'h30C0, 1, 0);
    xfer(1, adr(1, 0, 2'd2, 12'h555, 8'hAA), 16'hA05A, 1, 0);
    // R3: clear status ignores address
    xfer(1, adr(1, 1, 2'd3, 12'hFFF, 8'hFF), 16'h5033, 1, 0);
    // R4: program
    xfer(1, adr(0, 1, 2'd2, 12'h3C3, 8'h7E), 16'hBEEF, 1, 0);
    xfer(1, adr(0, 0, 2'd1, 12'h000, 8'hFF), 16'h0000, 1, 0);
    // R5: read status, R6: read configuration
    xfer(0, adr(1, 1, 2'd1, 12'h0F0, 8'h00), 16'h0080, 1, 16'h0080);
    xfer(0, adr(0, 1, 2'd3, 12'hA5A, 8'h3C), 16'h0000, 1, 16'h002C);
    // R7: buffers enabled refuses every class
    xfer(1, adr(1, 0, 2'd2, 12'hABC, 8'h11), 16'h20D0, 0, 0);
    xfer(1, adr(0, 0, 2'd2, 12'hABC, 8'h11), 16'h1234, 0, 0);
    xfer(0, adr(1, 1, 2'd2, 12'hABC, 8'h11), 16'h0000, 0, 16'h7777);
    // R8: undefined read and unknown setup byte
    xfer(0, adr(1, 0, 2'd1, 12'h111, 8'h22), 16'h0000, 1, 16'h4444);
    xfer(0, adr(0, 0, 2'd1, 12'h111, 8'h22), 16'h0000, 1, 16'h4444);
    xfer(1, adr(1, 0, 2'd1, 12'h111, 8'h22), 16'h7701, 1, 0);
    // R9: mixed back-to-back traffic
    for (int i = 0; i < 12; i++) begin
      logic [31:0] a = 32'h9E37_79B9 * (i + 1);
      xfer(i[0], a, 16'(a ^ (a >> 16)) & 16'h60FF | 16'h6000, i[2] | i[1], 16'(a));
    end
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule